// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits between a serial-memory protocol engine and a nonvolatile array model. Once the engine has decoded a write sequence, it hands over the starting byte address. Each data byte it receives is then passed on with a one-cycle strobe. The block keeps the bytes in a one-page holding buffer. The address inside the page advances after every byte and wraps back to the first byte of the same page. The page row itself never changes.

When the engine reports the stop that ends the sequence, the block decides whether the commit may go ahead. The commit is refused if no byte was received, if the protect input is high, or if the page lies in the sealed top region after the seal has been set. When the commit goes ahead, the block writes every buffered byte into the array through a single-byte write port, one byte per clock in ascending offset order. It holds `busy` high for a fixed number of clocks, and it ignores every request for that whole window.

The top region is sealed by a one-cycle seal request that the protocol engine raises after it decodes the dedicated sealing sequence. Once set, the seal stays set until the next reset.

The controller is a four-state machine:
- `ST_IDLE`: waiting for a sequence.
- `ST_COLLECT`: gathering bytes.
- `ST_DRAIN`: walking the buffer and issuing array writes.
- `ST_HOLD`: waiting for the rest of the busy window.

Its transitions are:
- *open*: `ST_IDLE` to `ST_COLLECT` on a start.
- *reopen*: `ST_COLLECT` to `ST_COLLECT` on a repeated start, which discards the collected bytes.
- *commit*: `ST_COLLECT` to `ST_DRAIN` on an allowed stop.
- *abandon*: `ST_COLLECT` to `ST_IDLE` on an empty or refused stop.
- *drained*: `ST_DRAIN` to `ST_HOLD` after the last buffer slot.
- *release*: `ST_HOLD` to `ST_IDLE` when the busy window ends.

Top module: `page_commit_unit`

## Requirements
- R1: After reset, `busy` and `mem_we` are low and the seal is clear.
- R2: A start loads `start_addr`. The k-th byte after the start (counting from 0) is committed to the address whose upper `ADDR_W-PAGE_W` bits equal those of `start_addr` and whose low `PAGE_W` bits equal (start offset + k) mod 2^PAGE_W.
- R3: Past the last offset of a page, the next byte goes to offset 0 of the same page. With more than 2^PAGE_W bytes, each offset receives the last byte sent to it, so at most 2^PAGE_W writes happen.
- R4: Only the offsets that received a byte are written. Each such offset is written exactly once per commit, in strictly ascending offset order.
- R5: No array write happens before the stop. After an allowed stop, `busy` is high from the next cycle for exactly `CYCLE_CLKS` cycles, and every array write happens while `busy` is high.
- R6: While `busy` is high, start, byte, stop and seal requests are ignored. They neither extend the window nor cause writes nor set the seal.
- R7: If `protect_in` is high when the stop is taken, nothing is written and `busy` stays low.
- R8: A `seal_req` pulse in `ST_IDLE` sets the seal. After that, a sequence whose page lies in the top `SEAL_BYTES` of the address space writes nothing and raises no `busy`, while pages below that region still commit.
- R9: Before the seal is set, the top region commits like any other page. Once set, the seal stays set through later sequences until reset.
- R10: A stop with no byte received writes nothing and leaves `busy` low.
- R11: A start during `ST_COLLECT` discards the bytes already collected and reloads the address. A start has priority over a byte or stop in the same cycle, and a byte has priority over a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start of a write sequence; loads `start_addr` |
| start_addr | input | ADDR_W | Starting byte address of the sequence |
| byte_valid | input | 1 | One data byte is present on `byte_data` |
| byte_data | input | 8 | Received data byte |
| stop_valid | input | 1 | Stop ending the write sequence |
| protect_in | input | 1 | High inhibits every array write |
| seal_req | input | 1 | Decoded sealing sequence; seals the top region |
| busy | output | 1 | Commit window in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench builds the block with a 15-bit address, 64-byte pages and a 256-byte sealed region. It shortens `CYCLE_CLKS` to 100 clocks. That value exceeds the 64-slot drain plus one register stage, so the whole drain, its exact busy length and the requests injected during the window all fit in a few hundred cycles. With a full-size address, the top-region seal boundary, page-end wrap and over-length page writes can all be reached with real row values.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DRAIN   = 2'd2,
        ST_HOLD    = 2'd3
    } pgc_state_t;

endpackage

// File: rtl/pgc_page_buf.sv
module pgc_page_buf #(
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [PAGE_W-1:0] wr_off_i,
    input  logic [7:0]        wr_data_i,
    input  logic [PAGE_W-1:0] rd_off_i,
    output logic [7:0]        rd_data_o,
    output logic              rd_mark_o,
    output logic              any_o
);
    localparam int SLOTS = 1 << PAGE_W;

    logic [7:0]       data_q [SLOTS];
    logic [SLOTS-1:0] mark_q;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic hit;
        assign hit = wr_i && (wr_off_i == PAGE_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mark_q[g] <= 1'b0;
                data_q[g] <= 8'h00;
            end else if (clr_i) begin
                mark_q[g] <= 1'b0;
            end else if (hit) begin
                mark_q[g] <= 1'b1;
                data_q[g] <= wr_data_i;
            end
        end
    end

    assign rd_data_o = data_q[rd_off_i];
    assign rd_mark_o = mark_q[rd_off_i];
    assign any_o     = |mark_q;

    // R11: a clear empties the whole buffer
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !any_o);

    // R4: a write marks its slot
    wr_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> any_o);

endmodule

// File: rtl/pgc_cycle_timer.sv
module pgc_cycle_timer #(
    parameter int CYCLE_CLKS = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    output logic busy_o,
    output logic last_o
);
    localparam int CNT_W = $clog2(CYCLE_CLKS + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (kick_i) begin
            cnt_q <= CNT_W'(CYCLE_CLKS);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = (cnt_q != '0);
    assign last_o = (cnt_q == CNT_W'(1));

    // R6: a new window is never started inside a running one
    kick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |-> !busy_o);

    // R5: busy only rises after a kick
    rise_after_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(kick_i));

endmodule

// File: rtl/pgc_seal_guard.sv
module pgc_seal_guard #(
    parameter int ROW_W      = 9,
    parameter int SEAL_PAGES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             sealed_o,
    output logic             row_sealed_o
);
    localparam logic [ROW_W-1:0] FIRST_SEALED_ROW =
        ROW_W'((1 << ROW_W) - SEAL_PAGES);

    logic sealed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sealed_q <= 1'b0;
        end else if (set_i) begin
            sealed_q <= 1'b1;
        end
    end

    assign sealed_o     = sealed_q;
    assign row_sealed_o = sealed_q && (row_i >= FIRST_SEALED_ROW);

    // R9: once set the seal never clears before reset
    seal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sealed_o |=> sealed_o);

endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit
    import pgc_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int PAGE_W     = 6,
    parameter int SEAL_BYTES = 256,
    parameter int CYCLE_CLKS = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              stop_valid,
    input  logic              protect_in,
    input  logic              seal_req,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int ROW_W      = ADDR_W - PAGE_W;
    localparam int SEAL_PAGES = SEAL_BYTES / PAGE_BYTES;
    localparam logic [ADDR_W-1:0] SEAL_BASE =
        ADDR_W'((1 << ADDR_W) - SEAL_BYTES);
    localparam logic [PAGE_W-1:0] LAST_OFF = PAGE_W'(PAGE_BYTES - 1);

    pgc_state_t state_q, state_d;

    logic [ROW_W-1:0]  row_q;
    logic [PAGE_W-1:0] off_q;
    logic [PAGE_W-1:0] drain_q;
    logic              mem_we_q;
    logic [ADDR_W-1:0] mem_addr_q;
    logic [7:0]        mem_wdata_q;

    logic       take_start, take_byte, take_stop, take_seal, commit_go;
    logic       buf_any, buf_mark;
    logic [7:0] buf_rd;
    logic       tmr_busy, tmr_last;
    logic       sealed, row_sealed;

    // Request qualification: start beats byte, byte beats stop.
    assign take_start = start_valid &&
                        (state_q == ST_IDLE || state_q == ST_COLLECT);
    assign take_byte  = byte_valid && !start_valid && (state_q == ST_COLLECT);
    assign take_stop  = stop_valid && !start_valid && !byte_valid &&
                        (state_q == ST_COLLECT);
    assign take_seal  = seal_req && !start_valid && (state_q == ST_IDLE);
    assign commit_go  = take_stop && buf_any && !protect_in && !row_sealed;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_start) state_d = ST_COLLECT;        // open
            end
            ST_COLLECT: begin
                if (take_stop) begin
                    state_d = commit_go ? ST_DRAIN : ST_IDLE; // commit / abandon
                end
            end
            ST_DRAIN: begin
                if (drain_q == LAST_OFF) state_d = ST_HOLD;  // drained
            end
            ST_HOLD: begin
                if (tmr_last) state_d = ST_IDLE;             // release
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q       <= '0;
            off_q       <= '0;
            drain_q     <= '0;
            mem_we_q    <= 1'b0;
            mem_addr_q  <= '0;
            mem_wdata_q <= '0;
        end else begin
            if (take_start) begin
                row_q <= start_addr[ADDR_W-1:PAGE_W];
                off_q <= start_addr[PAGE_W-1:0];
            end else if (take_byte) begin
                off_q <= off_q + 1'b1;
            end

            if (commit_go) begin
                drain_q <= '0;
            end else if (state_q == ST_DRAIN) begin
                drain_q <= drain_q + 1'b1;
            end

            mem_we_q    <= (state_q == ST_DRAIN) && buf_mark;
            mem_addr_q  <= {row_q, drain_q};
            mem_wdata_q <= buf_rd;
        end
    end

    assign busy      = tmr_busy;
    assign mem_we    = mem_we_q;
    assign mem_addr  = mem_addr_q;
    assign mem_wdata = mem_wdata_q;

    pgc_page_buf #(.PAGE_W(PAGE_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (take_start),
        .wr_i      (take_byte),
        .wr_off_i  (off_q),
        .wr_data_i (byte_data),
        .rd_off_i  (drain_q),
        .rd_data_o (buf_rd),
        .rd_mark_o (buf_mark),
        .any_o     (buf_any)
    );

    pgc_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick_i (commit_go),
        .busy_o (tmr_busy),
        .last_o (tmr_last)
    );

    pgc_seal_guard #(.ROW_W(ROW_W), .SEAL_PAGES(SEAL_PAGES)) u_seal (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (take_seal),
        .row_i        (row_q),
        .sealed_o     (sealed),
        .row_sealed_o (row_sealed)
    );

    // R5
    write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R6
    busy_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state_q == ST_DRAIN || state_q == ST_HOLD));

    // R7
    protect_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && stop_valid && !start_valid && !byte_valid
         && protect_in) |=> (!busy && !mem_we));

    // R10
    empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && stop_valid && !start_valid && !byte_valid
         && !buf_any) |=> (!busy && !mem_we));

    // R8
    seal_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && sealed) |-> (mem_addr < SEAL_BASE));

    // R2
    page_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[ADDR_W-1:PAGE_W] == row_q));

endmodule

// File: tb/page_commit_unit_tb.sv
`timescale 1ns/1ps
module page_commit_unit_tb;
    localparam int AW   = 15;
    localparam int PW   = 6;
    localparam int T    = 100;
    localparam int SLOT = 1 << PW;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [7:0]    nbytes;
        logic [7:0]    seed;
        logic          prot;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{15'h0100, 8'd1,  8'h10, 1'b0},   // R2 single byte
        '{15'h0A3C, 8'd8,  8'h20, 1'b0},   // R3 wrap at page end
        '{15'h1234, 8'd70, 8'h40, 1'b0},   // R3 overlength overwrite
        '{15'h2005, 8'd3,  8'h90, 1'b1},   // R7 protected
        '{15'h7FC0, 8'd4,  8'hA0, 1'b0},   // R9 top region before seal
        '{15'h3000, 8'd0,  8'h00, 1'b0}    // R10 empty sequence
    };

    logic clk = 0, rst_n = 0;
    logic start_valid = 0, byte_valid = 0, stop_valid = 0;
    logic protect_in = 0, seal_req = 0;
    logic [AW-1:0] start_addr = '0;
    logic [7:0] byte_data = '0;
    logic busy, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;

    always #2 clk = ~clk;

    page_commit_unit #(.ADDR_W(AW), .PAGE_W(PW), .SEAL_BYTES(256),
                       .CYCLE_CLKS(T)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
        .start_addr(start_addr), .byte_valid(byte_valid),
        .byte_data(byte_data), .stop_valid(stop_valid),
        .protect_in(protect_in), .seal_req(seal_req), .busy(busy),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int n_chk = 0, n_fail = 0, wr_cnt = 0, order_err = 0;
    bit have_last = 0, done = 0;
    logic [PW-1:0] last_off;
    logic [7:0] shadow [1 << AW];

    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            shadow[mem_addr] = mem_wdata;
            wr_cnt++;
            if (have_last && mem_addr[PW-1:0] <= last_off) order_err++;
            last_off  = mem_addr[PW-1:0];
            have_last = 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_start(input logic [AW-1:0] a);
        have_last = 0;
        start_addr = a; start_valid = 1;
        @(negedge clk) start_valid = 0;
    endtask

    task automatic send_bytes(input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            byte_data = seed + 8'(i); byte_valid = 1;
            @(negedge clk);
        end
        byte_valid = 0;
    endtask

    task automatic send_stop(input bit p, output int bc);
        protect_in = p; stop_valid = 1;
        @(negedge clk) stop_valid = 0;
        bc = 0;
        while (busy && bc < 1000) begin
            bc++;
            @(negedge clk);
        end
        protect_in = 0;
        @(negedge clk);
    endtask

    task automatic run_seq(input logic [AW-1:0] a, input int n, input logic [7:0] seed,
                           input bit p, output int bc, output int wr);
        int base;
        base = wr_cnt;
        send_start(a);
        send_bytes(n, seed);
        chk(wr_cnt == base, "R5 no write before stop", wr_cnt - base, 0);
        send_stop(p, bc);
        wr = wr_cnt - base;
    endtask

    task automatic check_page(input logic [AW-1:0] a, input int n, input logic [7:0] seed,
                              input string tag);
        logic [7:0] ev [SLOT];
        bit         em [SLOT];
        for (int o = 0; o < SLOT; o++) em[o] = 0;
        for (int i = 0; i < n; i++) begin
            int o;
            o = (int'(a[PW-1:0]) + i) % SLOT;
            ev[o] = seed + 8'(i);
            em[o] = 1;
        end
        for (int o = 0; o < SLOT; o++) begin
            if (em[o]) begin
                logic [AW-1:0] ad;
                ad = {a[AW-1:PW], PW'(o)};
                chk(shadow[ad] == ev[o], tag, shadow[ad], ev[o]);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int bc, wr, ew, eb;
        for (int i = 0; i < (1 << AW); i++) shadow[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy after reset", busy, 0);
        chk(mem_we == 0, "R1 mem_we after reset", mem_we, 0);
        rst_n = 1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_seq(VECS[v].addr, int'(VECS[v].nbytes), VECS[v].seed, VECS[v].prot, bc, wr);
            ew = (VECS[v].nbytes == 0 || VECS[v].prot) ? 0 :
                 ((VECS[v].nbytes > SLOT) ? SLOT : int'(VECS[v].nbytes));
            eb = (ew == 0) ? 0 : T;
            $display("vector %0d", v);
            chk(wr == ew, "R2/R3/R7/R10 write count", wr, ew);
            chk(bc == eb, "R5/R7/R10 busy length", bc, eb);
            if (ew != 0) check_page(VECS[v].addr, int'(VECS[v].nbytes), VECS[v].seed,
                                    "R2 R3 R9 committed data");
            chk(order_err == 0, "R4 ascending order", order_err, 0);
        end

        // R6: requests during busy are ignored
        begin
            int base, k;
            base = wr_cnt;
            send_start(15'h0400);
            send_bytes(2, 8'hB0);
            stop_valid = 1;
            @(negedge clk) stop_valid = 0;
            bc = 0; k = 0;
            while (busy && bc < 1000) begin
                start_valid = (k == 0); start_addr = 15'h7F80;
                byte_valid  = (k == 1); byte_data = 8'hFF;
                stop_valid  = (k == 2);
                seal_req    = (k == 3);
                bc++; k++;
                @(negedge clk);
            end
            start_valid = 0; byte_valid = 0; stop_valid = 0; seal_req = 0;
            @(negedge clk);
            chk(bc == T, "R6 busy not extended", bc, T);
            chk(wr_cnt - base == 2, "R6 no extra writes", wr_cnt - base, 2);
            check_page(15'h0400, 2, 8'hB0, "R6 data intact");
            run_seq(15'h7F80, 1, 8'hD1, 0, bc, wr);
            chk(wr == 1, "R6 seal not set during busy", wr, 1);
        end

        // R11: restart discards earlier bytes
        begin
            int base;
            base = wr_cnt;
            send_start(15'h0200);
            send_bytes(3, 8'h50);
            send_start(15'h0300);
            send_bytes(2, 8'h60);
            send_stop(0, bc);
            chk(wr_cnt - base == 2, "R11 only new bytes", wr_cnt - base, 2);
            chk(shadow[15'h0200] == 8'h00, "R11 old bytes dropped", shadow[15'h0200], 0);
            check_page(15'h0300, 2, 8'h60, "R11 new data");
            chk(bc == T, "R11 busy length", bc, T);
        end

        // R8: seal the top region
        seal_req = 1;
        @(negedge clk) seal_req = 0;
        @(negedge clk);
        run_seq(15'h7F10, 2, 8'h33, 0, bc, wr);
        chk(wr == 0, "R8 sealed page not written", wr, 0);
        chk(bc == 0, "R8 sealed page no busy", bc, 0);
        run_seq(15'h7EFF, 1, 8'h44, 0, bc, wr);
        chk(wr == 1, "R8 page below seal written", wr, 1);
        chk(shadow[15'h7EFF] == 8'h44, "R8 data below seal", shadow[15'h7EFF], 8'h44);

        // R9: seal persists, reset clears it
        run_seq(15'h7FFF, 1, 8'h55, 0, bc, wr);
        chk(wr == 0, "R9 seal persists", wr, 0);
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && mem_we == 0, "R1 outputs in reset", busy, 0);
        rst_n = 1;
        @(negedge clk);
        run_seq(15'h7FFF, 1, 8'hC7, 0, bc, wr);
        chk(wr == 1, "R9 top writable after reset", wr, 1);
        chk(shadow[15'h7FFF] == 8'hC7, "R9 top data", shadow[15'h7FFF], 8'hC7);
        chk(order_err == 0, "R4 ascending order overall", order_err, 0);

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule